// File: doc/BRIEF.md
# Core Voltage Ramp Sequencer

This block brings a core supply from the voltage its regulator starts at on its own up or down to a per-device target voltage. The target comes from a register that holds a device-specific code. The block first checks that the target lies inside an allowed window. It then reads the regulator's output format (a linear exponent). After that it issues voltage-set writes. Each write moves the setpoint by one fixed step toward the target, and consecutive writes are separated by at least a set number of millisecond ticks. Once the target is reached, the block sends nothing more and the rail stays where it is.

Voltages at the block edge are unsigned fixed-point values with `FRAC` fractional bits of a volt. With the defaults, one unit is 2^-16 V and a step of 655 units is about 10 mV. The value written on the bus is the setpoint shifted right by `FRAC + exponent`. The block drives an abstract management-bus transaction interface with these parts:
- a request
- a read/write bit
- a command code
- a data word
- a one-cycle done or error reply

Byte-level signalling, packet error codes and analog settling are handled elsewhere.

Top module: `vid_ramp_stepper`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o` and `pm_req_o` are all low.
- R2: A run starts on a rising edge of `en_i`. If `tgt_i` is below `V_MIN` or above `V_MAX` (both bounds allowed), the block sets `err_o` and issues no bus request at all.
- R3: The first request of an accepted run is a read (`pm_wr_o`=0) with command code 0x20, which fetches the output format byte.
- R4: A format byte is accepted only if bits 7:5 are 000 and bits 4:0, taken as a signed exponent, are negative and no smaller than -`FRAC`. Any other format byte sets `err_o` and no write follows.
- R5: Every voltage write uses `pm_wr_o`=1, command code 0x21, and data equal to the new setpoint shifted right by `FRAC` + exponent.
- R6: Each write moves the setpoint from the previous value (the boot value for the first write) by exactly `STEP_Q` toward the target. The last write is clipped so that it lands exactly on the target and never goes past it, in either direction.
- R7: Between the done reply of one write and the request for the next write, at least `STEP_MS` millisecond ticks elapse.
- R8: Once the target has been written, `done_o` is high, `busy_o` is low, and no further request is made.
- R9: An error reply, or no reply within `TMO_CYC` cycles of a request, sets `err_o`. No further request is made, so the last acknowledged setpoint stays in force.
- R10: If the boot value equals the target, the run finishes with `done_o` after the format read, with no write.
- R11: `busy_o` is high while a run is in progress. At most one of `busy_o`, `done_o` and `err_o` is high at any time.
- R12: Lowering `en_i` clears `done_o` and `err_o`. A later rising edge starts a new run.
- R13: A request, together with its command, data and direction, stays unchanged until a reply arrives or the request times out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Rising edge starts a run; low clears the result flags |
| tgt_i | input | VW | Target voltage from the device register, fixed point |
| boot_i | input | VW | Voltage the regulator starts at, fixed point |
| tick_i | input | 1 | One-cycle pulse every millisecond |
| pm_req_o | output | 1 | Bus transaction request |
| pm_wr_o | output | 1 | 1 = write, 0 = read |
| pm_cmd_o | output | 8 | Command code |
| pm_data_o | output | 16 | Write data word |
| pm_done_i | input | 1 | Transaction completed (one cycle) |
| pm_err_i | input | 1 | Transaction failed (one cycle) |
| pm_rdata_i | input | 8 | Read data byte, valid with `pm_done_i` |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Target reached |
| err_o | output | 1 | Run aborted |

## Verification
The bench sweeps boot and target pairs across the window in both directions, together with several exponents. A design that clips the final step wrongly would overshoot the target or stall one unit short. A design that applies the exponent wrongly would write data words that are off by a power of two. The exact window bounds and the values one unit beyond them are driven. An off-by-one bound check would either reject a legal target or command an illegal one. Error replies, silent timeouts on both the read and a mid-ramp write, and malformed format bytes are each followed by a quiet period. This exposes a design that keeps stepping after a fault.

// File: rtl/vid_ramp_pkg.sv
package vid_ramp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_STEP,
    ST_WRITE,
    ST_WAIT,
    ST_DONE,
    ST_FAIL
  } vr_state_t;

  localparam logic [7:0] CMD_FMT_RD = 8'h20;
  localparam logic [7:0] CMD_VSET   = 8'h21;
endpackage

// File: rtl/vid_counter.sv
module vid_counter #(
  parameter int LIMIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic hit
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] TOP = W'(LIMIT);

  logic [W-1:0] cnt_q;

  assign hit = (cnt_q == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (inc && !hit) begin
      cnt_q <= cnt_q + W'(1);
    end
  end
endmodule

// File: rtl/vid_fmt_decode.sv
module vid_fmt_decode #(
  parameter int FRAC = 16,
  parameter int SHW  = $clog2(FRAC + 1)
) (
  input  logic [7:0]     fmt,
  output logic           ok,
  output logic [SHW-1:0] shift
);
  int mag;

  always_comb begin
    mag   = 32 - int'(fmt[4:0]);
    ok    = (fmt[7:5] == 3'b000) && fmt[4] && (mag <= FRAC);
    shift = ok ? SHW'(FRAC - mag) : '0;
  end
endmodule

// File: rtl/vid_step_next.sv
module vid_step_next #(
  parameter int VW     = 16,
  parameter int STEP_Q = 655
) (
  input  logic [VW-1:0] cur,
  input  logic [VW-1:0] tgt,
  output logic [VW-1:0] nxt
);
  localparam logic [VW:0] STEP = (VW+1)'(STEP_Q);

  logic [VW:0] gap;

  always_comb begin
    if (tgt >= cur) begin
      gap = {1'b0, tgt} - {1'b0, cur};
      nxt = (gap > STEP) ? VW'({1'b0, cur} + STEP) : tgt;
    end else begin
      gap = {1'b0, cur} - {1'b0, tgt};
      nxt = (gap > STEP) ? VW'({1'b0, cur} - STEP) : tgt;
    end
  end
endmodule

// File: rtl/vid_ramp_stepper.sv
module vid_ramp_stepper
  import vid_ramp_pkg::*;
#(
  parameter int VW      = 16,
  parameter int FRAC    = 16,
  parameter int STEP_Q  = 655,
  parameter int V_MIN   = 53740,
  parameter int V_MAX   = 60948,
  parameter int STEP_MS = 10,
  parameter int TMO_CYC = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [VW-1:0] tgt_i,
  input  logic [VW-1:0] boot_i,
  input  logic          tick_i,
  output logic          pm_req_o,
  output logic          pm_wr_o,
  output logic [7:0]    pm_cmd_o,
  output logic [15:0]   pm_data_o,
  input  logic          pm_done_i,
  input  logic          pm_err_i,
  input  logic [7:0]    pm_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o
);
  localparam int DW  = 16;
  localparam int SHW = $clog2(FRAC + 1);
  localparam logic [VW-1:0] WIN_LO = VW'(V_MIN);
  localparam logic [VW-1:0] WIN_HI = VW'(V_MAX);

  vr_state_t      state_q, state_d;
  logic           en_q;
  logic [VW-1:0]  tgt_q, tgt_d;
  logic [VW-1:0]  set_q, set_d;
  logic [VW-1:0]  nxt_q, nxt_d;
  logic [SHW-1:0] shift_q, shift_d;

  logic           start, in_window;
  logic           fmt_ok;
  logic [SHW-1:0] fmt_shift;
  logic [VW-1:0]  step_val;
  logic           gap_hit, tmo_hit;
  logic           in_xfer;

  assign start     = en_i && !en_q;
  assign in_window = (tgt_i >= WIN_LO) && (tgt_i <= WIN_HI);
  assign in_xfer   = (state_q == ST_READ) || (state_q == ST_WRITE);

  vid_fmt_decode #(.FRAC(FRAC), .SHW(SHW)) u_fmt (
    .fmt   (pm_rdata_i),
    .ok    (fmt_ok),
    .shift (fmt_shift)
  );

  vid_step_next #(.VW(VW), .STEP_Q(STEP_Q)) u_step (
    .cur (set_q),
    .tgt (tgt_q),
    .nxt (step_val)
  );

  vid_counter #(.LIMIT(STEP_MS)) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state_q != ST_WAIT),
    .inc   (tick_i),
    .hit   (gap_hit)
  );

  vid_counter #(.LIMIT(TMO_CYC)) u_tmo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!in_xfer),
    .inc   (1'b1),
    .hit   (tmo_hit)
  );

  always_comb begin
    state_d = state_q;
    tgt_d   = tgt_q;
    set_d   = set_q;
    nxt_d   = nxt_q;
    shift_d = shift_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          tgt_d   = tgt_i;
          set_d   = boot_i;
          state_d = in_window ? ST_READ : ST_FAIL;
        end
      end
      ST_READ: begin
        if (pm_err_i) begin
          state_d = ST_FAIL;
        end else if (pm_done_i) begin
          if (!fmt_ok) begin
            state_d = ST_FAIL;
          end else begin
            shift_d = fmt_shift;
            state_d = (set_q == tgt_q) ? ST_DONE : ST_STEP;
          end
        end else if (tmo_hit) begin
          state_d = ST_FAIL;
        end
      end
      ST_STEP: begin
        nxt_d   = step_val;
        state_d = ST_WRITE;
      end
      ST_WRITE: begin
        if (pm_err_i) begin
          state_d = ST_FAIL;
        end else if (pm_done_i) begin
          set_d   = nxt_q;
          state_d = (nxt_q == tgt_q) ? ST_DONE : ST_WAIT;
        end else if (tmo_hit) begin
          state_d = ST_FAIL;
        end
      end
      ST_WAIT: begin
        if (gap_hit) state_d = ST_STEP;
      end
      ST_DONE, ST_FAIL: begin
        if (!en_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      en_q    <= 1'b0;
      tgt_q   <= '0;
      set_q   <= '0;
      nxt_q   <= '0;
      shift_q <= '0;
    end else begin
      state_q <= state_d;
      en_q    <= en_i;
      tgt_q   <= tgt_d;
      set_q   <= set_d;
      nxt_q   <= nxt_d;
      shift_q <= shift_d;
    end
  end

  assign pm_req_o  = in_xfer;
  assign pm_wr_o   = (state_q == ST_WRITE);
  assign pm_cmd_o  = (state_q == ST_WRITE) ? CMD_VSET : CMD_FMT_RD;
  assign pm_data_o = (state_q == ST_WRITE) ? DW'(nxt_q >> shift_q) : '0;
  assign busy_o    = (state_q != ST_IDLE) && (state_q != ST_DONE) && (state_q != ST_FAIL);
  assign done_o    = (state_q == ST_DONE);
  assign err_o     = (state_q == ST_FAIL);
endmodule

// File: rtl/vid_ramp_stepper_chk.sv
module vid_ramp_stepper_chk #(
  parameter int VW      = 16,
  parameter int V_MIN   = 53740,
  parameter int V_MAX   = 60948,
  parameter int STEP_MS = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_i,
  input logic          pm_req_o,
  input logic          pm_wr_o,
  input logic [7:0]    pm_cmd_o,
  input logic [15:0]   pm_data_o,
  input logic          pm_done_i,
  input logic          pm_err_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic [VW-1:0] tgt_q
);
  localparam int GW = $clog2(STEP_MS + 1);

  logic [GW-1:0] gap_q;
  logic          seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (pm_req_o && !pm_wr_o) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (pm_req_o && pm_wr_o && pm_done_i) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (tick_i && (gap_q != GW'(STEP_MS))) begin
      gap_q  <= gap_q + GW'(1);
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_req_o && !pm_done_i && !pm_err_i) |=>
      ((pm_req_o && $stable(pm_cmd_o) && $stable(pm_data_o) && $stable(pm_wr_o)) || err_o)); // R13

  AST_QUIET_END: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || err_o) |-> !pm_req_o); // R8

  AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy_o, done_o, err_o})); // R11

  AST_WIN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_req_o && pm_wr_o) |-> ((tgt_q >= VW'(V_MIN)) && (tgt_q <= VW'(V_MAX)))); // R2

  AST_STEP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pm_req_o) && pm_wr_o && seen_q) |-> (gap_q >= GW'(STEP_MS))); // R7
endmodule

bind vid_ramp_stepper vid_ramp_stepper_chk #(
  .VW(VW), .V_MIN(V_MIN), .V_MAX(V_MAX), .STEP_MS(STEP_MS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
  .pm_req_o(pm_req_o), .pm_wr_o(pm_wr_o), .pm_cmd_o(pm_cmd_o), .pm_data_o(pm_data_o),
  .pm_done_i(pm_done_i), .pm_err_i(pm_err_i),
  .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .tgt_q(tgt_q)
);

// File: tb/vid_ramp_stepper_test.sv
module vid_ramp_stepper_test;
  localparam int CLK_PERIOD = 10;
  localparam int TPER    = 3;
  localparam int STEP_Q  = 655;
  localparam int V_MIN   = 53740;
  localparam int V_MAX   = 60948;
  localparam int STEP_MS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] tgt_v = '0;
  logic [15:0] boot_v = '0;
  logic        tick = 1'b0;
  logic        req, wr;
  logic [7:0]  cmd;
  logic [15:0] data;
  logic        bus_done = 1'b0;
  logic        bus_err = 1'b0;
  logic [7:0]  rdata = '0;
  logic        busy, done, err;

  int n_run = 0;
  int n_fail = 0;
  int ms_cnt = 0;

  int lg_cmd [64];
  int lg_wr  [64];
  int lg_data[64];
  int lg_rms [64];
  int lg_dms [64];
  int ew     [64];

  vid_ramp_stepper uut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .tgt_i(tgt_v), .boot_i(boot_v), .tick_i(tick),
    .pm_req_o(req), .pm_wr_o(wr), .pm_cmd_o(cmd), .pm_data_o(data),
    .pm_done_i(bus_done), .pm_err_i(bus_err), .pm_rdata_i(rdata),
    .busy_o(busy), .done_o(done), .err_o(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      repeat (TPER - 1) @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
      tick = 1'b1;
      ms_cnt++;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic run(input int boot, input int tgt, input int fmt, input int lat,
                     input int fkind, input int fidx, input string tag);
    int nreq = 0;
    int infl = 0;
    int wc = 0;
    int extra = 0;
    int ex, sh, nw, v, exp_n;
    bit fmt_ok, inw, exp_err;

    en = 1'b0; bus_done = 1'b0; bus_err = 1'b0;
    boot_v = 16'(boot); tgt_v = 16'(tgt); rdata = 8'(fmt);
    repeat (3) @(negedge clk);
    #1;
    chk(!done && !err && !busy, "R12 flags clear after en low", {29'd0, busy, done, err}, 0);

    ex = ((fmt & 16) != 0) ? (fmt & 31) - 32 : (fmt & 31);
    fmt_ok = ((fmt >> 5) == 0) && (ex < 0) && (-ex <= 16);
    sh = 16 + ex;
    inw = (tgt >= V_MIN) && (tgt <= V_MAX);
    v = boot; nw = 0;
    while (v != tgt) begin
      if (tgt > v) v = (tgt - v > STEP_Q) ? v + STEP_Q : tgt;
      else         v = (v - tgt > STEP_Q) ? v - STEP_Q : tgt;
      ew[nw] = v; nw++;
    end
    if (!inw) begin exp_n = 0; exp_err = 1; end
    else if (fkind != 0 && fidx == 0) begin exp_n = 1; exp_err = 1; end
    else if (!fmt_ok) begin exp_n = 1; exp_err = 1; end
    else if (fkind != 0 && fidx <= nw) begin exp_n = fidx + 1; exp_err = 1; end
    else begin exp_n = nw + 1; exp_err = 0; end

    @(negedge clk);
    en = 1'b1;
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk); #1;
      bus_done = 1'b0; bus_err = 1'b0;
      if (done || err) break;
      if (c == 0) chk(busy, "R11 busy during run", busy, 1);
      if (req) begin
        if (infl == 0) begin
          lg_cmd[nreq] = cmd; lg_wr[nreq] = wr; lg_data[nreq] = data; lg_rms[nreq] = ms_cnt;
          nreq++; infl = 1; wc = 0;
        end else begin
          wc++;
        end
        if (wc >= lat) begin
          if (fkind != 0 && nreq - 1 == fidx) begin
            if (fkind == 1) begin bus_err = 1'b1; infl = 0; end
          end else begin
            bus_done = 1'b1; lg_dms[nreq-1] = ms_cnt; infl = 0;
          end
        end
      end
    end

    for (int c = 0; c < 80; c++) begin
      @(negedge clk); #1;
      bus_done = 1'b0; bus_err = 1'b0;
      if (req) extra++;
    end

    chk(err == exp_err && done == !exp_err, {tag, " outcome"}, {30'd0, done, err}, exp_err ? 1 : 2);
    chk(busy == 1'b0, "R11 busy low at end", busy, 0);
    chk(extra == 0, "R8 R9 no request after finish", extra, 0);
    chk(nreq == exp_n, {tag, " request count"}, nreq, exp_n);
    for (int j = 0; j < nreq && j < exp_n; j++) begin
      if (j == 0) begin
        chk(lg_cmd[0] == 8'h20 && lg_wr[0] == 0, "R3 format read first", lg_cmd[0], 8'h20);
      end else begin
        chk(lg_cmd[j] == 8'h21 && lg_wr[j] == 1, "R5 write command code", lg_cmd[j], 8'h21);
        chk(lg_data[j] == ((ew[j-1] >> sh) & 16'hFFFF), "R6 R5 setpoint data",
            lg_data[j], (ew[j-1] >> sh) & 16'hFFFF);
        if (j >= 2)
          chk(lg_rms[j] - lg_dms[j-1] >= STEP_MS, "R7 tick spacing",
              lg_rms[j] - lg_dms[j-1], STEP_MS);
      end
    end
  endtask

  initial begin
    repeat (CLK_PERIOD * 150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !done && !err && !req, "R1 reset state", {28'd0, req, busy, done, err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run(58982, 53740, 8'h14, 0, 0, 0, "R6 ramp down to lower bound");
    run(53740, 60948, 8'h10, 2, 0, 0, "R6 ramp up to upper bound");
    run(57000, 57000 + 3 * STEP_Q, 8'h17, 1, 0, 0, "R6 exact multiple");
    run(57500, 57400, 8'h14, 0, 0, 0, "R6 single clipped step");
    run(56000, 56000, 8'h14, 0, 0, 0, "R10 boot equals target");
    run(58000, V_MIN - 1, 8'h14, 0, 0, 0, "R2 below window");
    run(58000, V_MAX + 1, 8'h14, 0, 0, 0, "R2 above window");
    run(56000, 58000, 8'h00, 0, 0, 0, "R4 zero exponent");
    run(56000, 58000, 8'h05, 0, 0, 0, "R4 positive exponent");
    run(56000, 58000, 8'h54, 0, 0, 0, "R4 non-linear mode bits");
    run(56000, 58000, 8'h14, 0, 1, 0, "R9 error on read");
    run(54000, 60000, 8'h14, 1, 1, 3, "R9 error mid ramp");
    run(60000, 54000, 8'h14, 0, 2, 2, "R9 timeout mid ramp");
    run(60000, 54000, 8'h14, 0, 2, 0, "R9 timeout on read");

    for (int bi = 0; bi < 4; bi++) begin
      for (int ti = 0; ti < 4; ti++) begin
        int bv, tv;
        bv = (bi == 0) ? 53740 : (bi == 1) ? 56000 : (bi == 2) ? 58982 : 60948;
        tv = (ti == 0) ? 53740 : (ti == 1) ? 55555 : (ti == 2) ? 58000 : 60948;
        run(bv, tv, (ti == 3) ? 8'h19 : 8'h14, bi & 1, 0, 0, "R6 sweep");
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule